// File: doc/BRIEF.md
# Integer ALU with Registered Condition Flags

This block is the integer execution unit of a general-purpose processor datapath. Each cycle it takes an operation code, a lane size (8, 16, 32 or 64 bits), a source operand and a destination operand. It produces the result combinationally, together with a write enable for the register file. Carry, zero, sign and overflow flags are computed alongside the result and captured in flag registers on the clock edge when an operation is presented.

A predicate evaluator reads the stored flags and reports whether a selected condition holds. Branch, conditional-set and conditional-move logic elsewhere in the pipeline use that output. Signed orderings come from the sign and overflow flags, and unsigned orderings from the carry and zero flags. Decode and memory operands are handled upstream.

Operand bits above the selected lane size are ignored. Results are returned zero-extended to the full datapath width.

Top module: `int_alu_cc`

## Requirements
- R1: Opcodes are 0 increment, 1 decrement, 2 negate, 3 complement, 4 add, 5 subtract, 6 low-half multiply, 7 xor, 8 or, 9 and, 10 left shift, 11 arithmetic right shift, 12 logical right shift, 13 address-add, 14 compare, 15 test. Lane size codes are 0=8, 1=16, 2=32 and 3=64 bits. The result equals the operation applied to the lane-sized operands (D op S, or unary on D), truncated to the lane and zero-extended, with operand bits above the lane ignored.
- R2: The carry flag is set on a carry out of the lane's top bit for add and increment. It is set on a borrow (unsigned D < S, with increment/decrement using S=1) for subtract, decrement and compare. Negate sets it when D is non-zero.
- R3: The zero flag is set when the lane result is zero. The sign flag copies the lane result's top bit.
- R4: The overflow flag is set on two's-complement overflow of add, increment, subtract, decrement, negate and compare, in either direction.
- R5: And, or, xor, test and complement clear the carry and overflow flags.
- R6: For multiply, the result is the low lane of the signed product. Carry and overflow are both set exactly when the full signed product does not fit the lane.
- R7: The shift count is the source masked to log2(lane) bits, so an 8-bit shift by 0xFF shifts by 7. Carry receives the last bit shifted out. Overflow is result-sign XOR carry for left shift, and 0 for right shifts.
- R8: A shift whose masked count is zero writes the lane-masked destination and leaves all flags unchanged.
- R9: Address-add writes the lane-masked D+S and leaves all flags unchanged.
- R10: Compare (D−S) and test (D&S) update the flags and drive the write enable low. All other operations drive it high.
- R11: Flags update only on a clock edge with op_valid high. They hold otherwise and clear to zero on synchronous reset.
- R12: Condition codes 4 greater ~(SF^OF)&~ZF, 5 greater-or-equal ~(SF^OF), 6 less SF^OF and 7 less-or-equal (SF^OF)|ZF evaluate the stored flags.
- R13: Condition codes 0 equal ZF, 1 not-equal ~ZF, 2 negative SF, 3 non-negative ~SF, 8 above ~CF&~ZF, 9 above-or-equal ~CF, 10 below CF and 11 below-or-equal CF|ZF evaluate the stored flags. Codes 12 to 15 evaluate false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (R1) |
| op_size | input | 2 | Lane size code (R1) |
| src_i | input | 64 | Source operand S |
| dst_i | input | 64 | Destination operand D |
| cond_sel | input | 4 | Condition code to evaluate (R12, R13) |
| result_o | output | 64 | Lane result, zero-extended |
| wr_en_o | output | 1 | Result write enable |
| cf_o | output | 1 | Stored carry flag |
| zf_o | output | 1 | Stored zero flag |
| sf_o | output | 1 | Stored sign flag |
| of_o | output | 1 | Stored overflow flag |
| cond_true_o | output | 1 | Selected condition holds |

## Verification
The bench builds the block with the default 64-bit datapath, which exposes all four lane sizes and shift-count masks of 3, 4, 5 and 6 bits. That width lets the vectors reach each lane's overflow boundary and carry out of the full word. It also covers a 32-bit shift count of 33 masking to 1, and a 64-bit count of 64 masking to zero. Predicate checks compare operand pairs whose signed and unsigned orderings disagree, including a case where the subtraction overflows.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned XLEN  = 64;
    localparam int unsigned CNT_W = $clog2(XLEN);

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [3:0] {
        OP_INC, OP_DEC, OP_NEG, OP_NOT, OP_ADD, OP_SUB, OP_MUL, OP_XOR,
        OP_OR,  OP_AND, OP_SHL, OP_SAR, OP_SHR, OP_LEA, OP_CMP, OP_TEST
    } alu_op_e;

    typedef enum logic [1:0] { LANE_8, LANE_16, LANE_32, LANE_64 } lane_e;

    typedef enum logic [3:0] {
        CC_EQ, CC_NE, CC_NEG, CC_NNEG, CC_GT, CC_GE, CC_LT, CC_LE,
        CC_ABV, CC_AE, CC_BLW, CC_BE
    } cond_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    function automatic int unsigned lane_bits(lane_e sz);
        case (sz)
            LANE_8:  return XLEN / 8;
            LANE_16: return XLEN / 4;
            LANE_32: return XLEN / 2;
            default: return XLEN;
        endcase
    endfunction

    function automatic word_t lane_mask(lane_e sz);
        return {XLEN{1'b1}} >> (XLEN - lane_bits(sz));
    endfunction

    function automatic logic lane_sign(word_t v, lane_e sz);
        word_t m;
        m = lane_mask(sz);
        return |(v & (m ^ (m >> 1)));
    endfunction

    function automatic word_t lane_sext(word_t v, lane_e sz);
        word_t m;
        m = lane_mask(sz);
        return lane_sign(v, sz) ? (v | ~m) : (v & m);
    endfunction

    function automatic logic [CNT_W-1:0] lane_count(word_t s, lane_e sz);
        word_t c;
        c = s & word_t'(lane_bits(sz) - 1);
        return c[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
(
    input  alu_op_e op,
    input  lane_e   sz,
    input  word_t   src,
    input  word_t   dst,
    output word_t   res,
    output logic    wr_en,
    output logic    flag_upd,
    output flags_t  flag_nxt
);

    word_t                   m, msb, dm, sm, x, y;
    logic [XLEN:0]           sum, dif, carry_bit;
    word_t                   add_r, sub_r, shr_src;
    logic                    add_cf, add_of, sub_cf, sub_of;
    logic signed [2*XLEN-1:0] prod;
    logic signed [XLEN-1:0]  sar_v;
    logic [CNT_W-1:0]        cnt;
    logic                    cf, of;

    always_comb begin
        m         = lane_mask(sz);
        msb       = m ^ (m >> 1);
        dm        = dst & m;
        sm        = src & m;
        carry_bit = {1'b0, m} + {{XLEN{1'b0}}, 1'b1};

        x = (op == OP_NEG) ? '0 : dm;
        if (op == OP_INC || op == OP_DEC) y = word_t'(1);
        else if (op == OP_NEG)            y = dm;
        else                              y = sm;

        sum    = {1'b0, x} + {1'b0, y};
        dif    = {1'b0, x} - {1'b0, y};
        add_r  = sum[XLEN-1:0] & m;
        sub_r  = dif[XLEN-1:0] & m;
        add_cf = |(sum & carry_bit);
        sub_cf = x < y;
        add_of = (lane_sign(x, sz) == lane_sign(y, sz)) &&
                 (lane_sign(add_r, sz) != lane_sign(x, sz));
        sub_of = (lane_sign(x, sz) != lane_sign(y, sz)) &&
                 (lane_sign(sub_r, sz) != lane_sign(x, sz));

        prod = $signed({{XLEN{lane_sign(dst, sz)}}, lane_sext(dst, sz)}) *
               $signed({{XLEN{lane_sign(src, sz)}}, lane_sext(src, sz)});

        cnt     = lane_count(src, sz);
        shr_src = dm >> (cnt - 1'b1);
        sar_v   = $signed(lane_sext(dst, sz)) >>> cnt;

        res      = '0;
        wr_en    = 1'b1;
        flag_upd = 1'b1;
        cf       = 1'b0;
        of       = 1'b0;

        case (op)
            OP_INC, OP_ADD: begin
                res = add_r; cf = add_cf; of = add_of;
            end
            OP_DEC, OP_NEG, OP_SUB: begin
                res = sub_r; cf = sub_cf; of = sub_of;
            end
            OP_CMP: begin
                res = sub_r; cf = sub_cf; of = sub_of; wr_en = 1'b0;
            end
            OP_NOT:  res = ~dm & m;
            OP_XOR:  res = dm ^ sm;
            OP_OR:   res = dm | sm;
            OP_AND:  res = dm & sm;
            OP_TEST: begin
                res = dm & sm; wr_en = 1'b0;
            end
            OP_MUL: begin
                res = prod[XLEN-1:0] & m;
                cf  = prod != {{XLEN{lane_sign(res, sz)}}, lane_sext(res, sz)};
                of  = cf;
            end
            OP_SHL: begin
                res      = (dm << cnt) & m;
                cf       = (cnt != '0) && |(dm & (msb >> (cnt - 1'b1)));
                of       = lane_sign(res, sz) ^ cf;
                flag_upd = cnt != '0;
            end
            OP_SHR: begin
                res      = dm >> cnt;
                cf       = (cnt != '0) && shr_src[0];
                flag_upd = cnt != '0;
            end
            OP_SAR: begin
                res      = word_t'(sar_v) & m;
                cf       = (cnt != '0) && shr_src[0];
                flag_upd = cnt != '0;
            end
            default: begin
                res      = (dst + src) & m;
                flag_upd = 1'b0;
            end
        endcase

        flag_nxt = '{cf: cf, zf: (res == '0), sf: lane_sign(res, sz), of: of};
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  flags_t nxt,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= nxt;
    end

    // R11: no update request, flags keep their value
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(q));

    // R11: synchronous reset clears every flag
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_pkg::*;
(
    input  flags_t    f,
    input  logic [3:0] sel,
    output logic      hit
);

    logic lt_s;

    always_comb begin
        lt_s = f.sf ^ f.of;
        case (cond_e'(sel))
            CC_EQ:   hit = f.zf;
            CC_NE:   hit = ~f.zf;
            CC_NEG:  hit = f.sf;
            CC_NNEG: hit = ~f.sf;
            CC_GT:   hit = ~lt_s & ~f.zf;
            CC_GE:   hit = ~lt_s;
            CC_LT:   hit = lt_s;
            CC_LE:   hit = lt_s | f.zf;
            CC_ABV:  hit = ~f.cf & ~f.zf;
            CC_AE:   hit = ~f.cf;
            CC_BLW:  hit = f.cf;
            CC_BE:   hit = f.cf | f.zf;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [1:0]  op_size,
    input  logic [63:0] src_i,
    input  logic [63:0] dst_i,
    input  logic [3:0]  cond_sel,
    output logic [63:0] result_o,
    output logic        wr_en_o,
    output logic        cf_o,
    output logic        zf_o,
    output logic        sf_o,
    output logic        of_o,
    output logic        cond_true_o
);

    alu_op_e op;
    lane_e   sz;
    flags_t  nxt, cur;
    logic    upd_req;

    assign op = alu_op_e'(op_code);
    assign sz = lane_e'(op_size);

    alu_datapath u_dp (
        .op       (op),
        .sz       (sz),
        .src      (src_i),
        .dst      (dst_i),
        .res      (result_o),
        .wr_en    (wr_en_o),
        .flag_upd (upd_req),
        .flag_nxt (nxt)
    );

    alu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .upd (op_valid & upd_req),
        .nxt (nxt),
        .q   (cur)
    );

    alu_cond_eval u_cond (
        .f   (cur),
        .sel (cond_sel),
        .hit (cond_true_o)
    );

    assign cf_o = cur.cf;
    assign zf_o = cur.zf;
    assign sf_o = cur.sf;
    assign of_o = cur.of;

    // R10: compare and test never request a write
    p_cmp_test_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_CMP || op == OP_TEST)) |-> !wr_en_o);

    // R9: address-add leaves the stored flags alone
    p_lea_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LEA) |=> $stable({cf_o, zf_o, sf_o, of_o}));

    // R5: logical operations leave carry and overflow clear
    p_logic_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR ||
                      op == OP_TEST || op == OP_NOT)) |=> (!cf_o && !of_o));

    // R3: stored zero flag agrees with the result that produced it
    p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_ADD || op == OP_SUB || op == OP_XOR)) |=>
        (zf_o == ($past(result_o) == 64'd0)));

    // R6: multiply reports carry and overflow together
    p_mul_cf_eq_of_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_MUL) |=> (cf_o == of_o));

    // R8: zero masked shift count keeps the flags
    p_zero_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_SHL || op == OP_SHR || op == OP_SAR) &&
         lane_count(src_i, sz) == '0) |=> $stable({cf_o, zf_o, sf_o, of_o}));

endmodule

// File: tb/tb_int_alu_cc.sv
module tb_int_alu_cc;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [1:0]  op_size;
    logic [63:0] src_i, dst_i;
    logic [3:0]  cond_sel;
    logic [63:0] result_o;
    logic        wr_en_o, cf_o, zf_o, sf_o, of_o, cond_true_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    int_alu_cc dut (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [63:0] d;
        logic [63:0] s;
        logic [63:0] r;
        logic        wr;
        logic        keep;
        logic [3:0]  f;     // {CF,ZF,SF,OF}
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  2'd3, 64'd1,       64'd2,       64'd3,        1'b1, 1'b0, 4'b0000, "R1 "},
        '{4'd4,  2'd0, 64'h7F,      64'h01,      64'h80,       1'b1, 1'b0, 4'b0011, "R4 "},
        '{4'd4,  2'd0, 64'h1234FF,  64'h01,      64'h0,        1'b1, 1'b0, 4'b1100, "R2 "},
        '{4'd5,  2'd2, 64'd1,       64'd2,       64'hFFFFFFFF, 1'b1, 1'b0, 4'b1010, "R2 "},
        '{4'd5,  2'd1, 64'h8000,    64'h1,       64'h7FFF,     1'b1, 1'b0, 4'b0001, "R4 "},
        '{4'd14, 2'd3, 64'd5,       64'd5,       64'd0,        1'b0, 1'b0, 4'b0100, "R10"},
        '{4'd15, 2'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 4'b0010, "R10"},
        '{4'd7,  2'd2, 64'hF0F0F0F0, 64'hF0F0F0F0, 64'h0,      1'b1, 1'b0, 4'b0100, "R5 "},
        '{4'd8,  2'd1, 64'h0F00,    64'h8000,    64'h8F00,     1'b1, 1'b0, 4'b0010, "R3 "},
        '{4'd9,  2'd0, 64'hF0,      64'h0F,      64'h0,        1'b1, 1'b0, 4'b0100, "R5 "},
        '{4'd2,  2'd2, 64'd1,       64'd0,       64'hFFFFFFFF, 1'b1, 1'b0, 4'b1010, "R2 "},
        '{4'd2,  2'd0, 64'h80,      64'd0,       64'h80,       1'b1, 1'b0, 4'b1011, "R4 "},
        '{4'd3,  2'd1, 64'h00FF,    64'd0,       64'hFF00,     1'b1, 1'b0, 4'b0010, "R5 "},
        '{4'd0,  2'd0, 64'h7F,      64'd0,       64'h80,       1'b1, 1'b0, 4'b0011, "R1 "},
        '{4'd1,  2'd3, 64'd0,       64'd0,       64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'b1010, "R1 "},
        '{4'd6,  2'd2, 64'h10000,   64'h10000,   64'h0,        1'b1, 1'b0, 4'b1101, "R6 "},
        '{4'd6,  2'd1, 64'hFFFF,    64'd3,       64'hFFFD,     1'b1, 1'b0, 4'b0010, "R6 "},
        '{4'd10, 2'd0, 64'h81,      64'hFF,      64'h80,       1'b1, 1'b0, 4'b0011, "R7 "},
        '{4'd12, 2'd1, 64'h8001,    64'd1,       64'h4000,     1'b1, 1'b0, 4'b1000, "R7 "},
        '{4'd11, 2'd0, 64'h80,      64'd3,       64'hF0,       1'b1, 1'b0, 4'b0010, "R7 "},
        '{4'd11, 2'd2, 64'h8000_0000, 64'd33,    64'hC000_0000, 1'b1, 1'b0, 4'b0010, "R7 "},
        '{4'd13, 2'd3, 64'h1000,    64'h20,      64'h1020,     1'b1, 1'b1, 4'b0000, "R9 "},
        '{4'd10, 2'd3, 64'd5,       64'd64,      64'd5,        1'b1, 1'b1, 4'b0000, "R8 "},
        '{4'd12, 2'd3, 64'd1,       64'd1,       64'd0,        1'b1, 1'b0, 4'b1100, "R3 "},
        '{4'd4,  2'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 1'b0, 4'b1101, "R2 "}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_now();
        return {cf_o, zf_o, sf_o, of_o};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [1:0] sz,
                         input logic [63:0] d, input logic [63:0] s);
        @(negedge clk);
        op_code = op; op_size = sz; dst_i = d; src_i = s; op_valid = 1'b1;
        #1;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // R12 R13: predicates after a 64-bit compare of d against s
    task automatic cond_pair(input logic [63:0] d, input logic [63:0] s);
        logic [63:0] diff;
        logic e;
        apply(4'd14, 2'd3, d, s);
        finish_op();
        diff = d - s;
        for (int c = 0; c < 16; c++) begin
            cond_sel = c[3:0];
            #1;
            case (c)
                0:  e = (d == s);
                1:  e = (d != s);
                2:  e = diff[63];
                3:  e = !diff[63];
                4:  e = ($signed(d) >  $signed(s));
                5:  e = ($signed(d) >= $signed(s));
                6:  e = ($signed(d) <  $signed(s));
                7:  e = ($signed(d) <= $signed(s));
                8:  e = (d >  s);
                9:  e = (d >= s);
                10: e = (d <  s);
                11: e = (d <= s);
                default: e = 1'b0;
            endcase
            chk(cond_true_o == e, (c >= 4 && c <= 7) ? "R12" : "R13",
                64'(cond_true_o), 64'(e));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] expf;
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_size = '0;
        src_i = '0; dst_i = '0; cond_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk(flags_now() == 4'b0000, "R11", 64'(flags_now()), 64'd0);
        cond_sel = 4'd0; #1;
        chk(cond_true_o == 1'b0, "R13", 64'(cond_true_o), 64'd0);
        cond_sel = 4'd1; #1;
        chk(cond_true_o == 1'b1, "R13", 64'(cond_true_o), 64'd1);

        expf = 4'b0000;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].sz, VEC[i].d, VEC[i].s);
            if (VEC[i].wr)
                chk(result_o == VEC[i].r, string'(VEC[i].tag), result_o, VEC[i].r);
            chk(wr_en_o == VEC[i].wr, "R10", 64'(wr_en_o), 64'(VEC[i].wr));
            finish_op();
            if (!VEC[i].keep) expf = VEC[i].f;
            chk(flags_now() == expf, string'(VEC[i].tag), 64'(flags_now()), 64'(expf));
        end

        // R11: idle cycles with flag-changing inputs present hold the flags
        op_code = 4'd4; op_size = 2'd3; dst_i = '0; src_i = '0;
        repeat (3) @(negedge clk);
        chk(flags_now() == expf, "R11", 64'(flags_now()), 64'(expf));

        // R11: reset in the middle of a run clears the flags
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(flags_now() == 4'b0000, "R11", 64'(flags_now()), 64'd0);

        // R7: 16-bit left shift with count 0x13 masks to 3
        apply(4'd10, 2'd1, 64'hF001, 64'h13);
        chk(result_o == 64'h8008, "R7", result_o, 64'h8008);
        finish_op();
        chk(flags_now() == 4'b1010, "R7", 64'(flags_now()), 64'hA);

        cond_pair(64'd3, 64'd5);
        cond_pair(64'd5, 64'd3);
        cond_pair(64'd7, 64'd7);
        cond_pair(64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        cond_pair(64'h8000_0000_0000_0000, 64'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule